// File: doc/BRIEF.md
# Flash Read Buffer

This block lets a bus master read serial flash as if it were ordinary memory. A request/address/data/ready read port is served from a single line buffer that holds one contiguous, aligned run of flash bytes. When a read falls inside the buffered line, the word is returned from local storage one cycle later. When it does not, the block drops the old line and asks a flash sequence engine to refill the buffer. The engine is told which programmed sequence to run, the aligned start address and the byte length. The engine then streams the line back one 32-bit word per beat, in ascending address order.

Software-facing configuration arrives as plain inputs: the fill length in 8-byte units, the sequence number to run on a miss, an enable that lets every master use the buffer, and the identity of the one master served when that enable is clear. Two soft-reset inputs, one for the bus domain and one for the flash domain, clear the buffer only when both are high at the same time. Reads that arrive while both are held wait until both are released.

The controller has five states. ST_IDLE waits for a read. ST_RESP drives the ready pulse of a hit. ST_MISS holds the fill request until the engine acknowledges it. ST_FILL collects the streamed words. ST_FLUSH waits out the soft resets. The transitions are:
- IDLE to FLUSH when both resets are high. This takes priority over a read.
- IDLE to RESP on a hit, and IDLE to MISS on a miss.
- RESP back to IDLE.
- MISS to FILL on acknowledge.
- FILL to IDLE on the last beat, or FILL to FLUSH if both resets are high on that beat.
- FLUSH to IDLE once both resets are low.

Top module: `flash_read_buffer`

## Requirements
- R1: After reset, rd_ready, busy and fill_req are all 0, and the buffer holds no valid line.
- R2: A read that misses raises fill_req with fill_addr set to the read address rounded down to the line length. It also discards the previous line, so a later read of the old line misses again.
- R3: fill_seq carries cfg_seq_id as sampled when the miss was accepted. fill_req, fill_addr and fill_seq stay steady until the cycle fill_ack is high.
- R4: A read that hits returns the stored word with rd_ready high in the cycle after the request is first sampled, and starts no fill.
- R5: busy is 1 from the cycle after a miss is accepted until the final beat of the fill is taken, and 0 otherwise.
- R6: The line length in bytes is 8 shifted left by the index of the highest set bit of cfg_fill_units. A value of 0 gives 8 bytes, and the length is capped at BUF_BYTES. For example, units 128 gives 1024 bytes and units 3 gives 16 bytes. fill_bytes reports this length in bytes.
- R7: The engine delivers word k of the line, holding bytes fill_addr+4k to +4k+3, on the k-th beat. On a miss, rd_ready rises in the cycle after the beat that carries the requested word, with that word on rd_data.
- R8: Holding srst_bus and srst_flash high together invalidates the line, so the next read misses.
- R9: Either soft-reset input high on its own leaves the line valid, and reads still hit.
- R10: A read presented while both soft resets are high gets no rd_ready and starts no fill until both are low again.
- R11: With cfg_all_masters at 0, only reads whose rd_master equals cfg_owner can hit, and every other master's read misses. With cfg_all_masters at 1, every master can hit.
- R12: If both soft resets are high at any point during a fill, the line stays invalid after the fill ends.
- R13: rd_ready is a single-cycle pulse, and it only follows a cycle in which rd_req was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fill_units | input | 8 | Line length in 8-byte units, rounded down to a power of two |
| cfg_seq_id | input | 4 | Sequence number to run on a miss |
| cfg_all_masters | input | 1 | 1 lets every master use the buffer |
| cfg_owner | input | 4 | Master served when cfg_all_masters is 0 |
| srst_bus | input | 1 | Bus-domain soft reset |
| srst_flash | input | 1 | Flash-domain soft reset |
| rd_req | input | 1 | Read request, held until rd_ready |
| rd_master | input | 4 | Identity of the requesting master |
| rd_addr | input | 24 | Word-aligned byte address of the read |
| rd_data | output | 32 | Read data, valid while rd_ready is high |
| rd_ready | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A fill is in progress |
| fill_req | output | 1 | Fill request to the sequence engine |
| fill_seq | output | 4 | Sequence number for the fill |
| fill_addr | output | 24 | Aligned start address of the line |
| fill_bytes | output | 11 | Line length in bytes |
| fill_ack | input | 1 | Engine accepted the fill request |
| fill_beat_valid | input | 1 | A line word is present on fill_beat_data |
| fill_beat_data | input | 32 | Streamed line word |

## Verification
The properties rely on certain behaviour from the master and the engine. The master holds rd_req and rd_addr steady until rd_ready and lowers rd_req in the cycle of the pulse. The engine sends beats only after fill_ack and sends exactly one line's worth of them. The soft resets, when raised together, stay high for at least three bus cycles. The stimulus keeps within these limits because every read goes through one task that releases the request on the ready pulse. The engine model streams exactly fill_bytes/4 words after a single acknowledge, and every reset pulse in the bench lasts three or more cycles. All reads use word-aligned addresses.

// File: rtl/fb_pkg.sv
package fb_pkg;

    // log2 of the unit in which the fill length is programmed (8 bytes)
    localparam int FB_UNIT_LOG = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RESP  = 3'd1,
        ST_MISS  = 3'd2,
        ST_FILL  = 3'd3,
        ST_FLUSH = 3'd4
    } fb_state_e;

endpackage

// File: rtl/fb_len_decode.sv
// Turns the programmed unit count into a byte-length exponent:
// 3 + floor(log2(units)), 3 for zero, capped at MAX_EXP.
module fb_len_decode
    import fb_pkg::*;
#(
    parameter int UNIT_W  = 8,
    parameter int EXP_W   = 4,
    parameter int MAX_EXP = 10
) (
    input  logic [UNIT_W-1:0] units_i,
    output logic [EXP_W-1:0]  exp_o
);

    always_comb begin
        int top_bit;
        int value;
        top_bit = 0;
        for (int i = 0; i < UNIT_W; i++) begin
            if (units_i[i]) begin
                top_bit = i;
            end
        end
        value = FB_UNIT_LOG + top_bit;
        if (value > MAX_EXP) begin
            value = MAX_EXP;
        end
        exp_o = EXP_W'(value);
    end

endmodule

// File: rtl/fb_line_tag.sv
// Aligns an address down to a line of 2**exp_i bytes and gives the word
// index of the address inside that line.
module fb_line_tag #(
    parameter int ADDR_W   = 24,
    parameter int EXP_W    = 4,
    parameter int IDX_W    = 8,
    parameter int LANE_LOG = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [EXP_W-1:0]  exp_i,
    output logic [ADDR_W-1:0] aligned_o,
    output logic [IDX_W-1:0]  idx_o
);

    logic [ADDR_W-1:0] low_mask;

    assign low_mask  = (ADDR_W'(1) << exp_i) - ADDR_W'(1);
    assign aligned_o = addr_i & ~low_mask;
    assign idx_o     = IDX_W'((addr_i & low_mask) >> LANE_LOG);

endmodule

// File: rtl/fb_store.sv
// Line storage: one write port fed by the fill stream, one read port.
module fb_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/flash_read_buffer.sv
module flash_read_buffer
    import fb_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 32,
    parameter int BUF_BYTES = 1024,
    parameter int UNIT_W    = 8,
    parameter int SEQ_W     = 4,
    parameter int MST_W     = 4,
    localparam int BUF_LOG  = $clog2(BUF_BYTES),
    localparam int LEN_W    = BUF_LOG + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [UNIT_W-1:0] cfg_fill_units,
    input  logic [SEQ_W-1:0]  cfg_seq_id,
    input  logic              cfg_all_masters,
    input  logic [MST_W-1:0]  cfg_owner,
    input  logic              srst_bus,
    input  logic              srst_flash,
    input  logic              rd_req,
    input  logic [MST_W-1:0]  rd_master,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ready,
    output logic              busy,
    output logic              fill_req,
    output logic [SEQ_W-1:0]  fill_seq,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [LEN_W-1:0]  fill_bytes,
    input  logic              fill_ack,
    input  logic              fill_beat_valid,
    input  logic [DATA_W-1:0] fill_beat_data
);

    localparam int LANES     = DATA_W / 8;
    localparam int LANE_LOG  = $clog2(LANES);
    localparam int BUF_WORDS = BUF_BYTES / LANES;
    localparam int IDX_W     = $clog2(BUF_WORDS);
    localparam int EXP_W     = $clog2(BUF_LOG + 1);
    localparam int N_TAG     = 2;   // 0: stored line, 1: candidate line

    fb_state_e state_q, state_d;

    logic              valid_q;
    logic              want_q;
    logic              stale_q;
    logic              rd_ready_q;
    logic [ADDR_W-1:0] base_q;
    logic [EXP_W-1:0]  exp_q;
    logic [IDX_W-1:0]  req_idx_q;
    logic [IDX_W:0]    cnt_q;
    logic [SEQ_W-1:0]  seq_q;
    logic [DATA_W-1:0] rd_data_q;

    logic [EXP_W-1:0]  cfg_exp;
    logic [EXP_W-1:0]  tag_exp [N_TAG];
    logic [ADDR_W-1:0] tag_al  [N_TAG];
    logic [IDX_W-1:0]  tag_idx [N_TAG];
    logic [DATA_W-1:0] store_rdata;
    logic [IDX_W:0]    words_m1;

    logic served, flush_now, both_low, accept, hit, beat, last_beat;

    // ---------------- length and line decode ----------------
    fb_len_decode #(
        .UNIT_W (UNIT_W),
        .EXP_W  (EXP_W),
        .MAX_EXP(BUF_LOG)
    ) u_len (
        .units_i(cfg_fill_units),
        .exp_o  (cfg_exp)
    );

    assign tag_exp[0] = exp_q;
    assign tag_exp[1] = cfg_exp;

    for (genvar g = 0; g < N_TAG; g++) begin : g_tag
        fb_line_tag #(
            .ADDR_W  (ADDR_W),
            .EXP_W   (EXP_W),
            .IDX_W   (IDX_W),
            .LANE_LOG(LANE_LOG)
        ) u_tag (
            .addr_i   (rd_addr),
            .exp_i    (tag_exp[g]),
            .aligned_o(tag_al[g]),
            .idx_o    (tag_idx[g])
        );
    end

    fb_store #(
        .DATA_W(DATA_W),
        .DEPTH (BUF_WORDS),
        .IDX_W (IDX_W)
    ) u_store (
        .clk    (clk),
        .we_i   (beat),
        .waddr_i(cnt_q[IDX_W-1:0]),
        .wdata_i(fill_beat_data),
        .raddr_i(tag_idx[0]),
        .rdata_o(store_rdata)
    );

    // ---------------- decode ----------------
    assign served    = cfg_all_masters || (rd_master == cfg_owner);
    assign flush_now = srst_bus && srst_flash;
    assign both_low  = !srst_bus && !srst_flash;
    assign accept    = (state_q == ST_IDLE) && rd_req && !rd_ready_q && !flush_now;
    assign hit       = valid_q && served && (tag_al[0] == base_q);
    assign beat      = (state_q == ST_FILL) && fill_beat_valid;
    assign words_m1  = ((IDX_W+1)'(1) << (exp_q - EXP_W'(LANE_LOG))) - (IDX_W+1)'(1);
    assign last_beat = beat && (cnt_q == words_m1);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (flush_now) begin
                    state_d = ST_FLUSH;
                end else if (accept) begin
                    state_d = hit ? ST_RESP : ST_MISS;
                end
            end
            ST_RESP: state_d = ST_IDLE;
            ST_MISS: begin
                if (fill_ack) begin
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (last_beat) begin
                    state_d = flush_now ? ST_FLUSH : ST_IDLE;
                end
            end
            ST_FLUSH: begin
                if (both_low) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- registered outputs and line state ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q    <= 1'b0;
            want_q     <= 1'b0;
            stale_q    <= 1'b0;
            rd_ready_q <= 1'b0;
            base_q     <= '0;
            exp_q      <= EXP_W'(FB_UNIT_LOG);
            req_idx_q  <= '0;
            cnt_q      <= '0;
            seq_q      <= '0;
            rd_data_q  <= '0;
        end else begin
            rd_ready_q <= 1'b0;
            if (flush_now) begin
                valid_q <= 1'b0;
                if (state_q == ST_MISS || state_q == ST_FILL) begin
                    stale_q <= 1'b1;
                end
            end
            if (accept) begin
                if (hit) begin
                    rd_data_q  <= store_rdata;
                    rd_ready_q <= 1'b1;
                end else begin
                    valid_q   <= 1'b0;
                    base_q    <= tag_al[1];
                    exp_q     <= cfg_exp;
                    req_idx_q <= tag_idx[1];
                    want_q    <= 1'b1;
                    cnt_q     <= '0;
                    seq_q     <= cfg_seq_id;
                    stale_q   <= 1'b0;
                end
            end
            if (beat) begin
                cnt_q <= cnt_q + 1'b1;
                if (want_q && (cnt_q[IDX_W-1:0] == req_idx_q)) begin
                    rd_data_q  <= fill_beat_data;
                    rd_ready_q <= 1'b1;
                    want_q     <= 1'b0;
                end
                if (last_beat) begin
                    valid_q <= !(stale_q || flush_now);
                end
            end
        end
    end

    assign rd_ready   = rd_ready_q;
    assign rd_data    = rd_data_q;
    assign busy       = (state_q == ST_MISS) || (state_q == ST_FILL);
    assign fill_req   = (state_q == ST_MISS);
    assign fill_addr  = base_q;
    assign fill_seq   = seq_q;
    assign fill_bytes = LEN_W'(1) << exp_q;

endmodule

// File: rtl/fb_checker.sv
module fb_checker #(
    parameter int ADDR_W = 24,
    parameter int SEQ_W  = 4,
    parameter int LEN_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              rd_ready,
    input logic              busy,
    input logic              fill_req,
    input logic              fill_ack,
    input logic [ADDR_W-1:0] fill_addr,
    input logic [SEQ_W-1:0]  fill_seq,
    input logic [LEN_W-1:0]  fill_bytes,
    input logic              srst_bus,
    input logic              srst_flash
);

    // R13: completion is a single-cycle pulse
    p_ready_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |=> !rd_ready);

    // R13: completion only follows a request
    p_ready_has_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> $past(rd_req));

    // R3: request fields hold until acknowledged
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_ack) |=> (fill_req && $stable(fill_addr) && $stable(fill_seq)));

    // R5: a pending fill request always shows busy
    p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> busy);

    // R6: the fill start is aligned to the fill length
    p_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> ((fill_addr & ADDR_W'(fill_bytes - 1'b1)) == '0));

    // R10: no fill is started while both soft resets are held
    p_flush_blocks_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_bus && srst_flash && !busy) |=> !fill_req);

endmodule

bind flash_read_buffer fb_checker #(
    .ADDR_W(ADDR_W),
    .SEQ_W (SEQ_W),
    .LEN_W (LEN_W)
) i_fb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_ready  (rd_ready),
    .busy      (busy),
    .fill_req  (fill_req),
    .fill_ack  (fill_ack),
    .fill_addr (fill_addr),
    .fill_seq  (fill_seq),
    .fill_bytes(fill_bytes),
    .srst_bus  (srst_bus),
    .srst_flash(srst_flash)
);

// File: tb/test_flash_read_buffer.sv
`timescale 1ns/1ps
module test_flash_read_buffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_fill_units = 8'd2;
    logic [3:0]  cfg_seq_id = 4'h7;
    logic        cfg_all_masters = 1'b1;
    logic [3:0]  cfg_owner = 4'h0;
    logic        srst_bus = 1'b0;
    logic        srst_flash = 1'b0;
    logic        rd_req = 1'b0;
    logic [3:0]  rd_master = 4'h0;
    logic [23:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_ready;
    logic        busy;
    logic        fill_req;
    logic [3:0]  fill_seq;
    logic [23:0] fill_addr;
    logic [10:0] fill_bytes;
    logic        fill_ack = 1'b0;
    logic        fill_beat_valid = 1'b0;
    logic [31:0] fill_beat_data = '0;

    int checks = 0;
    int errors = 0;
    int fills = 0;
    logic [23:0] last_addr;
    int          last_bytes;
    logic [3:0]  last_seq;
    logic        busy_at_ack;

    always #10 clk = ~clk;   // 50 MHz

    flash_read_buffer i_flash_read_buffer (
        .clk(clk), .rst_n(rst_n),
        .cfg_fill_units(cfg_fill_units), .cfg_seq_id(cfg_seq_id),
        .cfg_all_masters(cfg_all_masters), .cfg_owner(cfg_owner),
        .srst_bus(srst_bus), .srst_flash(srst_flash),
        .rd_req(rd_req), .rd_master(rd_master), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_ready(rd_ready), .busy(busy),
        .fill_req(fill_req), .fill_seq(fill_seq), .fill_addr(fill_addr),
        .fill_bytes(fill_bytes), .fill_ack(fill_ack),
        .fill_beat_valid(fill_beat_valid), .fill_beat_data(fill_beat_data)
    );

    function automatic logic [31:0] flash_word(input logic [23:0] a);
        return {8'hC3, a};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // flash sequence engine model
    initial begin
        forever begin
            @(negedge clk);
            if (fill_req === 1'b1) begin
                fills++;
                last_addr  = fill_addr;
                last_bytes = int'(fill_bytes);
                last_seq   = fill_seq;
                repeat (2) @(negedge clk);
                busy_at_ack = busy;
                fill_ack = 1'b1;
                @(negedge clk);
                fill_ack = 1'b0;
                for (int i = 0; i < last_bytes / 4; i++) begin
                    fill_beat_valid = 1'b1;
                    fill_beat_data  = flash_word(last_addr + 24'(4 * i));
                    @(negedge clk);
                end
                fill_beat_valid = 1'b0;
            end
        end
    end

    task automatic do_read(input logic [3:0] m, input logic [23:0] a,
                           output logic [31:0] d, output int lat);
        @(negedge clk);
        rd_master = m;
        rd_addr   = a;
        rd_req    = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!rd_ready && lat < 3000);
        rd_req = 1'b0;
        d = rd_data;
    endtask

    task automatic settle();
        do @(negedge clk); while (busy || fill_beat_valid);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_reset(input bit b, input bit f, input int n);
        @(negedge clk);
        srst_bus = b;
        srst_flash = f;
        repeat (n) @(negedge clk);
        srst_bus = 1'b0;
        srst_flash = 1'b0;
    endtask

    task automatic t_reset();
        chk(rd_ready == 1'b0, "R1 rd_ready", 32'(rd_ready), 0);
        chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
        chk(fill_req == 1'b0, "R1 fill_req", 32'(fill_req), 0);
    endtask

    task automatic t_miss_hit();
        logic [31:0] d; int lat; int f0;
        cfg_fill_units = 8'd2; cfg_seq_id = 4'h7;
        f0 = fills;
        do_read(4'h0, 24'h000108, d, lat);
        chk(fills == f0 + 1, "R2 miss starts fill", 32'(fills - f0), 1);
        chk(last_addr == 24'h000100, "R2 aligned fill_addr", 32'(last_addr), 32'h100);
        chk(last_seq == 4'h7, "R3 fill_seq", 32'(last_seq), 7);
        chk(last_bytes == 16, "R6 fill_bytes units=2", 32'(last_bytes), 16);
        chk(d == flash_word(24'h108), "R7 miss data", d, flash_word(24'h108));
        chk(lat == 7, "R7 ready after requested beat", 32'(lat), 7);
        chk(busy_at_ack == 1'b1, "R5 busy during fill", 32'(busy_at_ack), 1);
        settle();
        chk(busy == 1'b0, "R5 busy cleared", 32'(busy), 0);
        f0 = fills;
        do_read(4'h0, 24'h00010C, d, lat);
        chk(lat == 1, "R4 hit latency", 32'(lat), 1);
        chk(d == flash_word(24'h10C), "R4 hit data", d, flash_word(24'h10C));
        do_read(4'h0, 24'h000100, d, lat);
        chk(d == flash_word(24'h100) && lat == 1, "R4 hit word0", d, flash_word(24'h100));
        chk(fills == f0, "R4 no fill on hit", 32'(fills - f0), 0);
    endtask

    task automatic t_lengths();
        logic [31:0] d; int lat; int f0;
        cfg_fill_units = 8'd0; cfg_seq_id = 4'h2;
        do_read(4'h0, 24'h00020C, d, lat); settle();
        chk(last_bytes == 8 && last_addr == 24'h208, "R6 units=0", 32'(last_bytes), 8);
        chk(last_seq == 4'h2, "R3 seq follows config", 32'(last_seq), 2);
        f0 = fills;
        do_read(4'h0, 24'h000108, d, lat); settle();
        chk(fills == f0 + 1, "R2 old line discarded", 32'(fills - f0), 1);
        cfg_fill_units = 8'd3;
        do_read(4'h0, 24'h0002F4, d, lat); settle();
        chk(last_bytes == 16 && last_addr == 24'h2F0, "R6 units=3", 32'(last_addr), 32'h2F0);
        cfg_fill_units = 8'd255;
        do_read(4'h0, 24'h000C00, d, lat); settle();
        chk(last_bytes == 1024 && last_addr == 24'h000C00, "R6 units=255 capped", 32'(last_bytes), 1024);
        cfg_fill_units = 8'd128;
        do_read(4'h0, 24'h001234, d, lat);
        chk(last_bytes == 1024 && last_addr == 24'h001000, "R6 units=128", 32'(last_addr), 32'h1000);
        chk(lat == 146 && d == flash_word(24'h1234), "R7 deep word latency", 32'(lat), 146);
        settle();
        f0 = fills;
        do_read(4'h0, 24'h0013FC, d, lat);
        chk(fills == f0 && d == flash_word(24'h13FC), "R4 hit last word of line", d, flash_word(24'h13FC));
    endtask

    task automatic t_single_reset();
        logic [31:0] d; int lat; int f0;
        f0 = fills;
        pulse_reset(1'b1, 1'b0, 4);
        do_read(4'h0, 24'h001000, d, lat);
        chk(fills == f0 && lat == 1, "R9 bus reset alone", 32'(fills - f0), 0);
        pulse_reset(1'b0, 1'b1, 4);
        do_read(4'h0, 24'h001004, d, lat);
        chk(fills == f0 && lat == 1, "R9 flash reset alone", 32'(fills - f0), 0);
    endtask

    task automatic t_both_reset();
        logic [31:0] d; int lat; int f0;
        f0 = fills;
        pulse_reset(1'b1, 1'b1, 4);
        do_read(4'h0, 24'h001000, d, lat); settle();
        chk(fills == f0 + 1, "R8 both resets invalidate", 32'(fills - f0), 1);
        chk(d == flash_word(24'h1000), "R8 refetched data", d, flash_word(24'h1000));
    endtask

    task automatic t_stall();
        int f0; int n; bit quiet;
        f0 = fills;
        quiet = 1'b1;
        @(negedge clk);
        srst_bus = 1'b1; srst_flash = 1'b1;
        repeat (2) @(negedge clk);
        rd_master = 4'h0; rd_addr = 24'h001010; rd_req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (rd_ready || fill_req) quiet = 1'b0;
        end
        chk(quiet, "R10 stalled while both resets held", 32'(quiet), 1);
        srst_bus = 1'b0;
        @(negedge clk);
        if (rd_ready || fill_req) quiet = 1'b0;
        chk(quiet, "R10 stalled while one reset still held", 32'(quiet), 1);
        srst_flash = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!rd_ready && n < 3000);
        rd_req = 1'b0;
        chk(rd_data == flash_word(24'h1010) && fills == f0 + 1, "R10 read resumes after release",
            rd_data, flash_word(24'h1010));
        settle();
    endtask

    task automatic t_masters();
        logic [31:0] d; int lat; int f0;
        cfg_fill_units = 8'd2; cfg_all_masters = 1'b0; cfg_owner = 4'h3;
        do_read(4'h3, 24'h000400, d, lat); settle();
        f0 = fills;
        do_read(4'h5, 24'h000404, d, lat); settle();
        do_read(4'h5, 24'h000404, d, lat); settle();
        chk(fills == f0 + 2, "R11 foreign master always misses", 32'(fills - f0), 2);
        chk(d == flash_word(24'h404), "R11 foreign master data", d, flash_word(24'h404));
        f0 = fills;
        do_read(4'h3, 24'h000408, d, lat);
        chk(fills == f0 && lat == 1, "R11 owner hits", 32'(lat), 1);
        cfg_all_masters = 1'b1;
        do_read(4'h5, 24'h00040C, d, lat);
        chk(fills == f0 && lat == 1 && d == flash_word(24'h40C), "R11 all masters hit", 32'(lat), 1);
    endtask

    task automatic t_flush_in_fill();
        logic [31:0] d; int lat; int f0;
        cfg_fill_units = 8'd128;
        do_read(4'h0, 24'h008000, d, lat);
        chk(lat == 5 && d == flash_word(24'h8000), "R7 first word early", 32'(lat), 5);
        pulse_reset(1'b1, 1'b1, 3);
        settle();
        f0 = fills;
        do_read(4'h0, 24'h008004, d, lat); settle();
        chk(fills == f0 + 1, "R12 flush during fill leaves line invalid", 32'(fills - f0), 1);
        f0 = fills;
        do_read(4'h0, 24'h008008, d, lat);
        chk(fills == f0 && lat == 1, "R12 clean refill becomes valid", 32'(lat), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_miss_hit();
        t_lengths();
        t_single_reset();
        t_both_reset();
        t_stall();
        t_masters();
        t_flush_in_fill();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule